// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the serial clock of an I2C master. A programmable divider turns the functional clock into a slower internal tick. Two phase counters then time the low and the high part of each SCL period in units of that tick. Each timing register holds two byte fields. The lower byte is used in standard/fast mode and the upper byte is used in high-speed mode. A fixed offset is added to each count: 7 ticks for the low phase and 5 ticks for the high phase. With a 96 MHz clock, a divider value of 23 with low/high values 13/15 gives 100 kHz. A divider value of 9 with values 5/7 gives 400 kHz.

The byte engine holds `run_i` high for as long as it wants clock pulses. The generator drives SCL low and then releases it. It does not start timing the high phase until the synchronized line actually reads high, so a slave that holds SCL low stretches the period. One-cycle strobes mark the start of each low phase and each high phase. The shifter uses them to change and to sample SDA. Timing settings are latched only while the module is disabled, so a new setting takes effect when the module is enabled again.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, and from the cycle after any cycle in which `enable_i` is low, `scl_drive_low_o`, `fall_o`, `rise_o` and `stretch_o` are all 0. SCL is released.
- R2: The internal tick fires once every `presc+1` functional clock cycles. Every phase lasts a whole number of ticks, and the tick restarts at the start of each phase.
- R3: In standard/fast mode (`hs_mode_i` = 0), the low phase holds `scl_drive_low_o` at 1 for exactly (`low_cfg[7:0]` + 7) × (`presc`+1) cycles.
- R4: In standard/fast mode, the high phase lasts (`high_cfg[7:0]` + 5) × (`presc`+1) cycles. It is counted from the cycle where `rise_o` is 1 up to, but not including, the next cycle where `fall_o` is 1.
- R5: With `hs_mode_i` = 1, bits [15:8] of both timing inputs replace bits [7:0] in the R3 and R4 formulas.
- R6: After SCL is released, `rise_o` waits for the line. It is 1 in the cycle after the second clock edge that follows the first edge at which `scl_in_i` is sampled high. Holding the line low longer delays the high phase by the same number of cycles.
- R7: `stretch_o` is 1 in every cycle from the release of SCL until the cycle before `rise_o`.
- R8: Changes to `presc_i`, `low_cfg_i`, `high_cfg_i` and `hs_mode_i` made while `enable_i` = 1 do not affect the period. The values present while `enable_i` is low are the ones used after the next enable.
- R9: If `run_i` is low when a high phase ends, SCL stays released and no further `fall_o` occurs. When `run_i` then rises while the block is idle, the low phase starts one cycle later.
- R10: `fall_o` is a single-cycle pulse in the first cycle of each low phase. `rise_o` is a single-cycle pulse in the first cycle of each high phase. The two never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Module enable; settings are latched while low |
| hs_mode_i | input | 1 | 1 selects the high-speed timing bytes |
| run_i | input | 1 | Request for clock pulses from the byte engine |
| presc_i | input | 8 | Tick divider value (divide by value+1) |
| low_cfg_i | input | 16 | Low-phase counts: [7:0] std/fast, [15:8] high-speed |
| high_cfg_i | input | 16 | High-phase counts: [7:0] std/fast, [15:8] high-speed |
| scl_in_i | input | 1 | Sampled SCL line level |
| scl_drive_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_o | output | 1 | Pulse at the start of each low phase |
| rise_o | output | 1 | Pulse at the start of each high phase |
| stretch_o | output | 1 | SCL is released but not yet seen high |

## Verification
The assertions assume that `scl_in_i` reads low whenever the block drives SCL low, as a wired-AND line does. The bench meets this by deriving the line from the drive output and a slave model that can only add low time. The low-phase bound assumes settings no larger than the parameter widths allow. Random stimulus draws divider, timing bytes, mode and stretch length, and it changes settings only while the block is disabled. The exception is the R8 case, which changes settings while enabled on purpose.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_tick_div.sv
// Divides the functional clock into the internal sampling tick.
module scl_tick_div #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] pcnt;

  assign tick_o = (pcnt == psc_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i)        pcnt <= '0;
    else if (pcnt == psc_i)  pcnt <= '0;
    else                     pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/scl_line_sync.sv
// Multi-flop synchronizer for the sampled SCL line.
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/scl_phase_ctl.sv
// Phase sequencer: low, wait-for-line, high, with tick-based counting.
module scl_phase_ctl
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             run_i,
  input  logic             line_hi_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] low_lim_i,
  input  logic [CNT_W-1:0] high_lim_i,
  output logic             clr_o,
  output logic             drive_low_o,
  output logic             fall_o,
  output logic             rise_o,
  output logic             stretch_o
);
  phase_e           state, nxt;
  logic [CNT_W-1:0] ph_cnt;
  logic             low_done, high_done, phase_done;

  assign low_done   = (state == PH_LOW)  && tick_i && (ph_cnt == low_lim_i  - 1'b1);
  assign high_done  = (state == PH_HIGH) && tick_i && (ph_cnt == high_lim_i - 1'b1);
  assign phase_done = low_done || high_done;

  assign clr_o = !en_i || (state == PH_IDLE) || (state == PH_WAIT) || phase_done;

  always_comb begin
    nxt = state;
    if (!en_i) begin
      nxt = PH_IDLE;
    end else begin
      unique case (state)
        PH_IDLE: if (run_i)     nxt = PH_LOW;
        PH_LOW:  if (low_done)  nxt = PH_WAIT;
        PH_WAIT: if (line_hi_i) nxt = PH_HIGH;
        PH_HIGH: if (high_done) nxt = run_i ? PH_LOW : PH_IDLE;
        default:                nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PH_IDLE;
      ph_cnt      <= '0;
      drive_low_o <= 1'b0;
      fall_o      <= 1'b0;
      rise_o      <= 1'b0;
      stretch_o   <= 1'b0;
    end else begin
      state       <= nxt;
      drive_low_o <= (nxt == PH_LOW);
      fall_o      <= (nxt == PH_LOW)  && (state != PH_LOW);
      rise_o      <= (nxt == PH_HIGH) && (state != PH_HIGH);
      stretch_o   <= (nxt == PH_WAIT);
      if (nxt != state || !en_i) ph_cnt <= '0;
      else if (tick_i && (state == PH_LOW || state == PH_HIGH))
        ph_cnt <= ph_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scl_rate_gen.sv
// Top: latches timing while disabled and wires divider, sync and sequencer.
module scl_rate_gen #(
  parameter int PSC_W       = 8,
  parameter int CFG_W       = 8,
  parameter int LOW_OFS     = 7,
  parameter int HIGH_OFS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable_i,
  input  logic               hs_mode_i,
  input  logic               run_i,
  input  logic [PSC_W-1:0]   presc_i,
  input  logic [2*CFG_W-1:0] low_cfg_i,
  input  logic [2*CFG_W-1:0] high_cfg_i,
  input  logic               scl_in_i,
  output logic               scl_drive_low_o,
  output logic               fall_o,
  output logic               rise_o,
  output logic               stretch_o
);
  localparam int CFG_TOT = 2 * CFG_W;
  localparam int CNT_W   = $clog2((1 << CFG_W) + LOW_OFS + HIGH_OFS);

  logic [PSC_W-1:0]   psc_q;
  logic [CFG_TOT-1:0] low_q, high_q;
  logic               hs_q;
  logic [CFG_W-1:0]   low_sel, high_sel;
  logic [CNT_W-1:0]   low_lim, high_lim;
  logic               tick, clr, line_hi;

  // Settings follow the inputs only while disabled.
  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
      hs_q   <= 1'b0;
    end else if (!enable_i) begin
      psc_q  <= presc_i;
      low_q  <= low_cfg_i;
      high_q <= high_cfg_i;
      hs_q   <= hs_mode_i;
    end
  end

  assign low_sel  = hs_q ? low_q[CFG_TOT-1:CFG_W]  : low_q[CFG_W-1:0];
  assign high_sel = hs_q ? high_q[CFG_TOT-1:CFG_W] : high_q[CFG_W-1:0];
  assign low_lim  = CNT_W'(low_sel)  + CNT_W'(LOW_OFS);
  assign high_lim = CNT_W'(high_sel) + CNT_W'(HIGH_OFS);

  scl_tick_div #(.PSC_W(PSC_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr),
    .psc_i  (psc_q),
    .tick_o (tick)
  );

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (scl_in_i),
    .q_o (line_hi)
  );

  scl_phase_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .en_i        (enable_i),
    .run_i       (run_i),
    .line_hi_i   (line_hi),
    .tick_i      (tick),
    .low_lim_i   (low_lim),
    .high_lim_i  (high_lim),
    .clr_o       (clr),
    .drive_low_o (scl_drive_low_o),
    .fall_o      (fall_o),
    .rise_o      (rise_o),
    .stretch_o   (stretch_o)
  );
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk #(
  parameter int PSC_W   = 8,
  parameter int CFG_W   = 8,
  parameter int LOW_OFS = 7
) (
  input logic clk,
  input logic rst,
  input logic enable_i,
  input logic scl_drive_low_o,
  input logic fall_o,
  input logic rise_o,
  input logic stretch_o
);
  localparam int LOW_MAX = ((1 << CFG_W) - 1 + LOW_OFS) * (1 << PSC_W);

  int low_run;
  always_ff @(posedge clk) begin
    if (rst || !scl_drive_low_o) low_run <= 0;
    else                         low_run <= low_run + 1;
  end

  p_off_released_r1: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (!scl_drive_low_o && !fall_o && !rise_o && !stretch_o));

  p_low_bound_r3: assert property (@(posedge clk) disable iff (rst)
    low_run <= LOW_MAX);

  p_rise_after_wait_r6: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> $past(stretch_o));

  p_stretch_released_r7: assert property (@(posedge clk) disable iff (rst)
    stretch_o |-> !scl_drive_low_o);

  p_fall_marks_low_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_drive_low_o) |-> fall_o);

  p_fall_in_low_r10: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> scl_drive_low_o);

  p_rise_released_r10: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> (!scl_drive_low_o && !stretch_o));

  p_strobes_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(fall_o && rise_o));
endmodule

bind scl_rate_gen scl_rate_gen_chk #(
  .PSC_W   (PSC_W),
  .CFG_W   (CFG_W),
  .LOW_OFS (LOW_OFS)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .enable_i        (enable_i),
  .scl_drive_low_o (scl_drive_low_o),
  .fall_o          (fall_o),
  .rise_o          (rise_o),
  .stretch_o       (stretch_o)
);

// File: tb/scl_rate_gen_bench.sv
`timescale 1ns/1ps
module scl_rate_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable_i = 1'b0, hs_mode_i = 1'b0, run_i = 1'b0;
  logic [7:0]  presc_i = '0;
  logic [15:0] low_cfg_i = '0, high_cfg_i = '0;
  logic        scl_line, slave_low;
  logic        scl_drive_low_o, fall_o, rise_o, stretch_o;
  int          tests = 0, fails = 0, stretch = 0, s_cnt = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  // Wired-AND line: master drive plus a slave that can extend low time.
  assign slave_low = (s_cnt > 0);
  assign scl_line  = !(scl_drive_low_o || slave_low);
  always @(negedge clk) begin
    if (scl_drive_low_o) s_cnt <= stretch;
    else if (s_cnt > 0)  s_cnt <= s_cnt - 1;
  end

  scl_rate_gen u_scl_rate_gen (
    .clk(clk), .rst(rst), .enable_i(enable_i), .hs_mode_i(hs_mode_i),
    .run_i(run_i), .presc_i(presc_i), .low_cfg_i(low_cfg_i),
    .high_cfg_i(high_cfg_i), .scl_in_i(scl_line),
    .scl_drive_low_o(scl_drive_low_o), .fall_o(fall_o), .rise_o(rise_o),
    .stretch_o(stretch_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int phase_len(input int fld, input int ofs, input int psc);
    return (fld + ofs) * (psc + 1);
  endfunction

  function automatic int wait_len(input int s);
    return ((s < 1) ? 1 : s) + 2;
  endfunction

  task automatic program_cfg(input int psc, input int lo, input int hi, input bit hs);
    @(negedge clk);
    enable_i = 1'b0; run_i = 1'b0;
    presc_i = 8'(psc); low_cfg_i = 16'(lo); high_cfg_i = 16'(hi); hs_mode_i = hs;
    @(negedge clk);
    @(negedge clk);
    enable_i = 1'b1; run_i = 1'b1;
  endtask

  // Measures one full period starting at a fall strobe; ends at the next fall.
  task automatic measure(input int expl, input int exph, input int s,
                         input string rl, input string rh);
    int l = 0, w = 0, h = 0, guard = 0;
    bit st_ok = 1;
    while (!fall_o && guard < 20000) begin @(negedge clk); guard++; end
    while (scl_drive_low_o && l < 80000) begin l++; @(negedge clk); end
    check(l == expl, rl, l, expl);
    while (!rise_o && w < 80000) begin
      if (!stretch_o || scl_drive_low_o) st_ok = 0;
      w++; @(negedge clk);
    end
    check(w == wait_len(s), "R6 line wait", w, wait_len(s));
    check(st_ok, "R7 stretch flag", st_ok, 1);
    while (!fall_o && h < 80000) begin h++; @(negedge clk); end
    check(h == exph, rh, h, exph);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!scl_drive_low_o && !fall_o && !rise_o && !stretch_o, "R1 reset outputs",
          {scl_drive_low_o, fall_o, rise_o, stretch_o}, 0);
    rst = 1'b0;

    // R3 R4: 100 kHz and 400 kHz settings on a 96 MHz reference
    stretch = 0;
    program_cfg(23, 13, 15, 1'b0);
    measure(480, 480, 0, "R3 100k low", "R4 100k high");
    measure(480, 480, 0, "R3 100k low", "R4 100k high");
    program_cfg(9, 5, 7, 1'b0);
    measure(120, 120, 0, "R3 400k low", "R4 400k high");

    // R2: divide by one, extreme low byte
    program_cfg(0, 255, 0, 1'b0);
    measure(262, 5, 0, "R2 psc0 low", "R2 psc0 high");

    // R5: high-speed bytes selected
    program_cfg(3, 16'h0A02, 16'h0C01, 1'b1);
    measure(phase_len(10, 7, 3), phase_len(12, 5, 3), 0, "R5 hs low", "R5 hs high");
    program_cfg(3, 16'h0A02, 16'h0C01, 1'b0);
    measure(phase_len(2, 7, 3), phase_len(1, 5, 3), 0, "R5 std low", "R5 std high");

    // R6 R7: slave stretching
    stretch = 9;
    program_cfg(2, 3, 4, 1'b0);
    measure(phase_len(3, 7, 2), phase_len(4, 5, 2), 9, "R3 stretch low", "R4 stretch high");
    stretch = 0;

    // R8: changes while enabled are ignored, applied after re-enable
    program_cfg(1, 4, 6, 1'b0);
    measure(phase_len(4, 7, 1), phase_len(6, 5, 1), 0, "R8 base low", "R8 base high");
    presc_i = 8'd4; low_cfg_i = 16'd9; high_cfg_i = 16'd2;
    measure(phase_len(4, 7, 1), phase_len(6, 5, 1), 0, "R8 ignored low", "R8 ignored high");
    program_cfg(4, 9, 2, 1'b0);
    measure(phase_len(9, 7, 4), phase_len(2, 5, 4), 0, "R8 applied low", "R8 applied high");

    // R9: run dropped, then restarted from idle
    run_i = 1'b0;
    begin
      int g = 0, falls = 0, lows = 0;
      while (!rise_o && g < 5000) begin @(negedge clk); g++; end
      repeat (phase_len(2, 5, 4) + 40) begin
        @(negedge clk);
        if (fall_o) falls++;
        if (scl_drive_low_o) lows++;
      end
      check(falls == 0 && lows == 0, "R9 idle after run drop", falls + lows, 0);
      run_i = 1'b1;
      @(negedge clk);
      check(fall_o && scl_drive_low_o, "R9 restart next cycle",
            {fall_o, scl_drive_low_o}, 3);
    end

    // R1: disable mid low phase
    @(negedge clk);
    enable_i = 1'b0;
    @(negedge clk);
    check(!scl_drive_low_o && !fall_o && !rise_o && !stretch_o, "R1 disable releases",
          {scl_drive_low_o, fall_o, rise_o, stretch_o}, 0);

    // R2 R3 R4 R5 R6: random settings
    for (int i = 0; i < 10; i++) begin
      int psc = $urandom_range(0, 5);
      int lo  = $urandom_range(0, 12);
      int hi  = $urandom_range(0, 12);
      int lo2 = $urandom_range(0, 12);
      int hi2 = $urandom_range(0, 12);
      bit hs  = 1'($urandom_range(0, 1));
      int s   = $urandom_range(0, 6);
      stretch = s;
      program_cfg(psc, (lo2 << 8) | lo, (hi2 << 8) | hi, hs);
      measure(phase_len(hs ? lo2 : lo, 7, psc), phase_len(hs ? hi2 : hi, 5, psc), s,
              "R3 random low", "R4 random high");
      measure(phase_len(hs ? lo2 : lo, 7, psc), phase_len(hs ? hi2 : hi, 5, psc), s,
              "R2 random low", "R2 random high");
    end
    stretch = 0;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule